// File: doc/BRIEF.md
# Interval Timer Bus Register Controller

This block sits between an 8-bit I/O bus and three interval-timer channels. It decodes byte reads and writes to three per-channel data ports and one control port. A second address window mirrors the first. Each write to the control port does one of three things. It can program one channel's access format, mode and BCD flag. It can freeze one channel's count. As a read-back command, it can freeze the counts of several channels at once.

For each channel the block turns byte writes into 16-bit load strobes and serves byte reads from either the live count or a frozen copy. A per-channel low/high toggle sets which byte comes next when a channel uses the two-byte format. The channels themselves count elsewhere. This block only hands them configuration, load values and latch strobes, and it takes in their live counts.

Top module: `tmr_bus_regs`

## Requirements
- R1: Addresses 0x40, 0x41 and 0x42 are the data ports of channels 0, 1 and 2, and 0x43 is the control port. Addresses 0x50 to 0x53 behave the same as 0x40 to 0x43. An access to any other address produces no strobe and reads back 0x00.
- R2: A control write holds the channel select in bits 7:6 (00, 01 or 10 for channels 0 to 2), the access format in bits 5:4 (01 low byte only, 10 high byte only, 11 low then high), the mode in bits 3:1 and BCD in bit 0. One cycle after the write, the chosen channel's `cfg_valid` is 1 and its `cfg_mode` and `cfg_bcd` show the new setting.
- R3: Mode codes 110 and 111 appear on `cfg_mode` as 010 and 011. All other codes pass through unchanged.
- R4: A read of the control port returns 0x00. A data-port write to a channel that has never been programmed raises no load strobe, and a read of such a channel returns 0x00.
- R5: In low-only format, a data write raises `load_stb` for exactly the next cycle with `load_val` = {0x00, data}. In high-only format the value is {data, 0x00}.
- R6: In low-then-high format, the first data write raises no strobe. The second write raises `load_stb` with `load_val` = {second byte, first byte}.
- R7: A control write that programs a channel returns that channel's toggle to the low byte and drops any pending latched value.
- R8: A control write with bits 5:4 = 00 captures that channel's live count on the write edge and pulses `latch_stb` in the next cycle. It leaves the mode, the access format and the BCD flag unchanged.
- R9: With no latch pending, a data read returns a byte of the live count. Low-only format returns bits 7:0 and high-only returns bits 15:8. Low-then-high format alternates low and high, starting from low.
- R10: A pending latched value is returned in place of the live count until it has been fully read. That is one read in single-byte formats, or the high-byte read in low-then-high format. Latch commands that arrive while a latch is pending are ignored.
- R11: A control write with bits 7:6 = 11 and bit 5 = 0 is a read-back command. It latches each programmed channel whose mask bit is set: bit 1 for channel 0, bit 2 for channel 1, bit 3 for channel 2. The R10 rule applies to each of those channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe, one cycle per byte |
| rd_en | input | 1 | Bus read strobe; ignored when wr_en is high |
| addr | input | 8 | I/O address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| live_cnt | input | 48 | Live 16-bit counts of channels 0..2 (channel 0 in the low bits) |
| cfg_valid | output | 3 | Channel has been programmed |
| cfg_mode | output | 9 | Normalized 3-bit mode per channel |
| cfg_bcd | output | 3 | BCD flag per channel |
| load_stb | output | 3 | One-cycle count load strobe per channel |
| load_val | output | 48 | 16-bit load value per channel |
| latch_stb | output | 3 | One-cycle pulse when a channel's count is captured |

## Verification
The hardest state to reach is the one where a channel's shared low/high toggle sits on the high byte while a latched value is pending. A new latch or read-back arriving then must be ignored, and the release must come on the high-byte read and not the first read. Directed sequences put a channel in the middle of a two-byte read before sending latch, read-back and reprogramming commands. A long random phase then mixes control words of every encoding with reads and writes on both address windows while the live counts change between accesses. A bench model checks every strobe and byte.

// File: rtl/tmr_regs_pkg.sv
package tmr_regs_pkg;
  localparam int N_CH  = 3;
  localparam int CNT_W = 16;
  localparam int MODE_W = 3;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_LH    = 2'b11
  } acc_e;

  // Collapse the don't-care top bit of modes 2 and 3.
  function automatic logic [MODE_W-1:0] norm_mode(input logic [MODE_W-1:0] m);
    return m[1] ? {1'b0, m[1:0]} : m;
  endfunction

  // Which byte of a 16-bit value a read returns.
  function automatic logic [7:0] pick_byte(input logic [CNT_W-1:0] v,
                                           input acc_e a, input logic hi);
    case (a)
      ACC_HI:  return v[15:8];
      ACC_LH:  return hi ? v[15:8] : v[7:0];
      default: return v[7:0];
    endcase
  endfunction
endpackage

// File: rtl/tmr_addr_dec.sv
module tmr_addr_dec
  import tmr_regs_pkg::*;
#(
  parameter logic [7:0] BASE_A = 8'h40,
  parameter logic [7:0] BASE_B = 8'h50
) (
  input  logic [7:0]      addr,
  output logic [N_CH-1:0] data_hit,
  output logic            ctrl_hit
);
  localparam logic [1:0] CTRL_IDX = 2'(N_CH);

  logic in_win;
  assign in_win = (addr[7:2] == BASE_A[7:2]) || (addr[7:2] == BASE_B[7:2]);

  for (genvar i = 0; i < N_CH; i++) begin : g_hit
    assign data_hit[i] = in_win && (addr[1:0] == 2'(i));
  end
  assign ctrl_hit = in_win && (addr[1:0] == CTRL_IDX);
endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
  import tmr_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cw_wr,
  input  acc_e              cw_acc,
  input  logic [MODE_W-1:0] cw_mode,
  input  logic              cw_bcd,
  input  logic              latch_req,
  input  logic              dat_wr,
  input  logic              dat_rd,
  input  logic [7:0]        wdata,
  input  logic [CNT_W-1:0]  live_cnt,
  output logic              cfg_valid,
  output logic [MODE_W-1:0] cfg_mode,
  output logic              cfg_bcd,
  output logic              load_stb,
  output logic [CNT_W-1:0]  load_val,
  output logic              latch_stb,
  output logic [7:0]        rd_byte
);
  acc_e             acc_q;
  logic             hi_q;
  logic [7:0]       stage_q;
  logic             pend_q;
  logic [CNT_W-1:0] lval_q;

  // Named internal events.
  logic latch_take, wr_ok, rd_ok, lh_first, rd_done;
  assign latch_take = latch_req && cfg_valid && !pend_q && !cw_wr;
  assign wr_ok      = dat_wr && cfg_valid;
  assign rd_ok      = dat_rd && cfg_valid;
  assign lh_first   = wr_ok && (acc_q == ACC_LH) && !hi_q;
  assign rd_done    = rd_ok && ((acc_q != ACC_LH) || hi_q);

  logic [CNT_W-1:0] rd_src;
  assign rd_src  = pend_q ? lval_q : live_cnt;
  assign rd_byte = cfg_valid ? pick_byte(rd_src, acc_q, hi_q) : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_valid <= 1'b0;
      cfg_mode  <= '0;
      cfg_bcd   <= 1'b0;
      acc_q     <= ACC_LO;
      hi_q      <= 1'b0;
      stage_q   <= '0;
      pend_q    <= 1'b0;
      lval_q    <= '0;
      load_stb  <= 1'b0;
      load_val  <= '0;
      latch_stb <= 1'b0;
    end else begin
      load_stb  <= 1'b0;
      latch_stb <= 1'b0;
      if (cw_wr) begin
        cfg_valid <= 1'b1;
        acc_q     <= cw_acc;
        cfg_mode  <= norm_mode(cw_mode);
        cfg_bcd   <= cw_bcd;
        hi_q      <= 1'b0;
        pend_q    <= 1'b0;
      end else begin
        if (latch_take) begin
          pend_q    <= 1'b1;
          lval_q    <= live_cnt;
          latch_stb <= 1'b1;
        end
        if (wr_ok) begin
          case (acc_q)
            ACC_HI: begin
              load_val <= {wdata, 8'h00};
              load_stb <= 1'b1;
            end
            ACC_LH: begin
              if (!hi_q) begin
                stage_q <= wdata;
                hi_q    <= 1'b1;
              end else begin
                load_val <= {wdata, stage_q};
                load_stb <= 1'b1;
                hi_q     <= 1'b0;
              end
            end
            default: begin
              load_val <= {8'h00, wdata};
              load_stb <= 1'b1;
            end
          endcase
        end
        if (rd_ok) begin
          if (acc_q == ACC_LH) hi_q <= ~hi_q;
          if (rd_done) pend_q <= 1'b0;
        end
      end
    end
  end

  // R4: an unprogrammed channel never loads
  p_unprog_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_valid |=> !load_stb);
  // R5: single low byte load has a zero upper byte
  p_lo_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok && !cw_wr && (acc_q == ACC_LO) |=> load_stb && (load_val[15:8] == 8'h00));
  // R6: first byte of a two-byte write stays silent
  p_lh_first_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lh_first && !cw_wr |=> !load_stb && hi_q);
  // R7: programming returns toggle to low and drops latch
  p_cw_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cw_wr |=> !hi_q && !pend_q);
  // R8: latch command keeps configuration
  p_latch_keeps_cfg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    latch_req && !cw_wr |=> $stable(cfg_mode) && $stable(acc_q) && $stable(cfg_bcd));
  // R10: pending value held until fully read
  p_pend_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && !cw_wr && !rd_done |=> pend_q && $stable(lval_q));
endmodule

// File: rtl/tmr_bus_regs.sv
module tmr_bus_regs
  import tmr_regs_pkg::*;
#(
  parameter logic [7:0] BASE_A = 8'h40,
  parameter logic [7:0] BASE_B = 8'h50
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic                    rd_en,
  input  logic [7:0]              addr,
  input  logic [7:0]              wdata,
  output logic [7:0]              rdata,
  input  logic [N_CH*CNT_W-1:0]   live_cnt,
  output logic [N_CH-1:0]         cfg_valid,
  output logic [N_CH*MODE_W-1:0]  cfg_mode,
  output logic [N_CH-1:0]         cfg_bcd,
  output logic [N_CH-1:0]         load_stb,
  output logic [N_CH*CNT_W-1:0]   load_val,
  output logic [N_CH-1:0]         latch_stb
);
  logic [N_CH-1:0] data_hit;
  logic            ctrl_hit;

  tmr_addr_dec #(.BASE_A(BASE_A), .BASE_B(BASE_B)) u_dec (
    .addr(addr), .data_hit(data_hit), .ctrl_hit(ctrl_hit)
  );

  logic ctrl_wr, rb_cmd;
  acc_e cw_acc;
  assign ctrl_wr = wr_en && ctrl_hit;
  assign cw_acc  = acc_e'(wdata[5:4]);
  assign rb_cmd  = ctrl_wr && (wdata[7:6] == 2'b11) && !wdata[5];

  logic [N_CH-1:0] cw_wr, latch_req, dat_wr, dat_rd;
  logic [7:0]      rd_byte [N_CH];

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    assign cw_wr[i]     = ctrl_wr && (wdata[7:6] == 2'(i)) && (cw_acc != ACC_LATCH);
    assign latch_req[i] = (ctrl_wr && (wdata[7:6] == 2'(i)) && (cw_acc == ACC_LATCH))
                        || (rb_cmd && wdata[i+1]);
    assign dat_wr[i]    = wr_en && data_hit[i];
    assign dat_rd[i]    = rd_en && !wr_en && data_hit[i];

    tmr_chan_regs u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .cw_wr     (cw_wr[i]),
      .cw_acc    (cw_acc),
      .cw_mode   (wdata[3:1]),
      .cw_bcd    (wdata[0]),
      .latch_req (latch_req[i]),
      .dat_wr    (dat_wr[i]),
      .dat_rd    (dat_rd[i]),
      .wdata     (wdata),
      .live_cnt  (live_cnt[i*CNT_W +: CNT_W]),
      .cfg_valid (cfg_valid[i]),
      .cfg_mode  (cfg_mode[i*MODE_W +: MODE_W]),
      .cfg_bcd   (cfg_bcd[i]),
      .load_stb  (load_stb[i]),
      .load_val  (load_val[i*CNT_W +: CNT_W]),
      .latch_stb (latch_stb[i]),
      .rd_byte   (rd_byte[i])
    );
  end

  always_comb begin
    rdata = 8'h00;
    for (int i = 0; i < N_CH; i++)
      if (data_hit[i]) rdata = rd_byte[i];
  end

  // R1: accesses outside both windows cause no strobe
  p_outside_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !data_hit[0] && !data_hit[1] && !data_hit[2] && !ctrl_hit
    |=> (load_stb == '0) && (latch_stb == '0));
  // R11: read-back never reprograms a channel
  p_rb_keeps_cfg_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rb_cmd |=> $stable(cfg_mode) && $stable(cfg_valid) && (load_stb == '0));
endmodule

// File: tb/tmr_bus_regs_tb.sv
module tmr_bus_regs_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0, wdata = '0;
  logic [7:0]  rdata;
  logic [47:0] live_cnt = '0;
  logic [2:0]  cfg_valid, cfg_bcd, load_stb, latch_stb;
  logic [8:0]  cfg_mode;
  logic [47:0] load_val;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_bus_regs dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .live_cnt(live_cnt), .cfg_valid(cfg_valid),
    .cfg_mode(cfg_mode), .cfg_bcd(cfg_bcd), .load_stb(load_stb),
    .load_val(load_val), .latch_stb(latch_stb)
  );

  int n_chk = 0, n_bad = 0;

  // bench model
  bit        m_valid [3];
  bit [1:0]  m_acc   [3];
  bit [2:0]  m_mode  [3];
  bit        m_bcd   [3];
  bit        m_hi    [3];
  bit [7:0]  m_stage [3];
  bit        m_pend  [3];
  bit [15:0] m_lval  [3];

  function automatic bit [2:0] exp_mode(bit [2:0] m);
    if (m == 3'b110) return 3'b010;
    if (m == 3'b111) return 3'b011;
    return m;
  endfunction

  // -1 = no port, 0..2 = data port, 3 = control
  function automatic int port_of(bit [7:0] a);
    if ((a >= 8'h40 && a <= 8'h43) || (a >= 8'h50 && a <= 8'h53)) return int'(a[1:0]);
    return -1;
  endfunction

  function automatic bit [7:0] exp_byte(int c);
    bit [15:0] v;
    if (!m_valid[c]) return 8'h00;
    v = m_pend[c] ? m_lval[c] : live_cnt[c*16 +: 16];
    if (m_acc[c] == 2'b10 || (m_acc[c] == 2'b11 && m_hi[c])) return v[15:8];
    return v[7:0];
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic do_wr(bit [7:0] a, bit [7:0] d, string tag);
    bit [2:0]  e_stb = '0, e_lat = '0;
    bit [15:0] e_val [3];
    int p;
    @(negedge clk);
    p = port_of(a);
    for (int c = 0; c < 3; c++) e_val[c] = '0;
    if (p == 3) begin
      if (d[7:6] != 2'b11) begin
        int c = int'(d[7:6]);
        if (d[5:4] != 2'b00) begin
          m_valid[c] = 1; m_acc[c] = d[5:4]; m_mode[c] = exp_mode(d[3:1]);
          m_bcd[c] = d[0]; m_hi[c] = 0; m_pend[c] = 0;
        end else if (m_valid[c] && !m_pend[c]) begin
          m_pend[c] = 1; m_lval[c] = live_cnt[c*16 +: 16]; e_lat[c] = 1;
        end
      end else if (!d[5]) begin
        for (int c = 0; c < 3; c++)
          if (d[c+1] && m_valid[c] && !m_pend[c]) begin
            m_pend[c] = 1; m_lval[c] = live_cnt[c*16 +: 16]; e_lat[c] = 1;
          end
      end
    end else if (p >= 0 && m_valid[p]) begin
      case (m_acc[p])
        2'b01: begin e_stb[p] = 1; e_val[p] = {8'h00, d}; end
        2'b10: begin e_stb[p] = 1; e_val[p] = {d, 8'h00}; end
        default: begin
          if (!m_hi[p]) begin m_stage[p] = d; m_hi[p] = 1; end
          else begin e_stb[p] = 1; e_val[p] = {d, m_stage[p]}; m_hi[p] = 0; end
        end
      endcase
    end
    wr_en = 1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 0;
    for (int c = 0; c < 3; c++) begin
      check(load_stb[c] == e_stb[c], tag, "load_stb", load_stb[c], e_stb[c]);
      if (e_stb[c])
        check(load_val[c*16 +: 16] == e_val[c], tag, "load_val", load_val[c*16 +: 16], e_val[c]);
      check(latch_stb[c] == e_lat[c], tag, "latch_stb", latch_stb[c], e_lat[c]);
      check(cfg_valid[c] == m_valid[c], tag, "cfg_valid", cfg_valid[c], m_valid[c]);
      if (m_valid[c]) begin
        check(cfg_mode[c*3 +: 3] == m_mode[c], tag, "cfg_mode", cfg_mode[c*3 +: 3], m_mode[c]);
        check(cfg_bcd[c] == m_bcd[c], tag, "cfg_bcd", cfg_bcd[c], m_bcd[c]);
      end
    end
  endtask

  task automatic do_rd(bit [7:0] a, string tag);
    int p;
    bit [7:0] e;
    @(negedge clk);
    p = port_of(a);
    rd_en = 1; addr = a;
    #1;
    e = (p >= 0 && p < 3) ? exp_byte(p) : 8'h00;
    check(rdata == e, tag, "rdata", rdata, e);
    if (p >= 0 && p < 3 && m_valid[p]) begin
      bit done = (m_acc[p] != 2'b11) || m_hi[p];
      if (m_acc[p] == 2'b11) m_hi[p] = ~m_hi[p];
      if (done) m_pend[p] = 0;
    end
    @(posedge clk); #1;
    rd_en = 0;
  endtask

  task automatic set_live(int c, bit [15:0] v);
    @(negedge clk);
    live_cnt[c*16 +: 16] = v;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd17));
    for (int c = 0; c < 3; c++) begin
      m_valid[c] = 0; m_acc[c] = 0; m_mode[c] = 0; m_bcd[c] = 0;
      m_hi[c] = 0; m_stage[c] = 0; m_pend[c] = 0; m_lval[c] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    check(cfg_valid == 3'b000, "R4", "reset cfg_valid", cfg_valid, 0);
    check(load_stb == 3'b000, "R4", "reset load_stb", load_stb, 0);

    // R4: unprogrammed channel and control-port read
    set_live(1, 16'h5A5A);
    do_wr(8'h41, 8'h77, "R4");
    do_rd(8'h41, "R4");
    do_rd(8'h43, "R4");
    // R2 / R6: channel 0 low-then-high, mode 2
    do_wr(8'h43, 8'h34, "R2");
    do_wr(8'h40, 8'h12, "R6");
    do_wr(8'h40, 8'h34, "R6");
    // R3: channel 1 low-only, mode 111 shown as 011, BCD
    do_wr(8'h43, 8'h5F, "R3");
    do_wr(8'h41, 8'hAB, "R5");
    // R1 / R5: channel 2 high-only through alias, mode 110
    do_wr(8'h53, 8'hAC, "R1");
    do_wr(8'h52, 8'hCD, "R5");
    // R1: outside windows
    do_wr(8'h44, 8'h99, "R1");
    do_wr(8'h60, 8'h00, "R1");
    do_rd(8'h4F, "R1");
    // R7: half-written then reprogrammed
    do_wr(8'h40, 8'h55, "R7");
    do_wr(8'h43, 8'h36, "R7");
    do_wr(8'h50, 8'h01, "R7");
    do_wr(8'h50, 8'h02, "R7");
    // R9: live reads alternate low, high
    set_live(0, 16'hBEEF);
    do_rd(8'h40, "R9");
    do_rd(8'h40, "R9");
    do_rd(8'h41, "R9");
    // R8 / R10: latch ch0, change live, second latch ignored
    do_wr(8'h43, 8'h00, "R8");
    set_live(0, 16'h1234);
    do_wr(8'h43, 8'h00, "R10");
    do_rd(8'h40, "R10");
    set_live(0, 16'h4321);
    do_wr(8'h43, 8'hCE, "R10");
    do_rd(8'h40, "R10");
    do_rd(8'h40, "R10");
    // R11: read-back of all channels, mid-read on ch0
    do_rd(8'h40, "R11");
    do_wr(8'h43, 8'hCE, "R11");
    set_live(1, 16'hFFFF);
    set_live(2, 16'h0F0F);
    do_rd(8'h41, "R11");
    do_rd(8'h52, "R11");
    do_rd(8'h40, "R11");
    do_rd(8'h40, "R11");
    do_wr(8'h43, 8'hEE, "R11");

    // random phase
    for (int n = 0; n < 600; n++) begin
      int k = int'($urandom_range(0, 9));
      bit [7:0] a = ($urandom_range(0, 1) ? 8'h40 : 8'h50) | 8'($urandom_range(0, 3));
      if ($urandom_range(0, 3) == 0)
        set_live(int'($urandom_range(0, 2)), 16'($urandom()));
      if (k == 0) a = 8'($urandom());
      if (k < 4) do_rd(a, "R9");
      else if (k < 7) do_wr({a[7:2], 2'b11}, 8'($urandom()), "R2");
      else do_wr(a, 8'($urandom()), "R6");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule